// File: doc/BRIEF.md
# FIFO Threshold DMA Request Gate

This block decides, every clock cycle, whether the DMA engine may service each of the three byte FIFOs of a parallel-port slave interface. Two of them carry traffic from the host (a command FIFO and a data FIFO). The third carries traffic back to the host. The block does not hold the FIFOs. It watches their fill levels and compares them against thresholds chosen from small encoded tables. The encoded steps are uneven, so the block decodes them and does not treat the code as a plain count.

Each forward path runs either under CPU control or under DMA control. Under CPU control the DMA request stays low, and a service flag rises under the same condition. A forward FIFO that holds fewer bytes than its threshold can still be released by an idle-gap timer. The timer counts the clock cycles since the last byte was pushed into that FIFO. A configuration register holds the thresholds, the mode bits and a ready bit that drives the host-facing ready line. Software loads the whole register at once through a write strobe.

Top module: `pgate_top`

## Requirements
- R1: While reset is active, every request and service output and `host_ready` are 0. Reset loads all three threshold codes with 2'b11, sets both forward mode bits to 0 (CPU) and clears the ready bit.
- R2: A forward path raises its request when its fill level is at least the decoded minimum for its code: 2'b00 → 4, 2'b01 → 8, 2'b10 → 16, 2'b11 → 28. Below that minimum it stays low unless the gap timer has released it (R5).
- R3: The forward mode bit selects the output. With 1 (DMA), `*_dma_req` carries the condition and `*_cpu_svc` stays 0. With 0 (CPU), `*_cpu_svc` carries the condition and `*_dma_req` stays 0.
- R4: `rev_dma_req` is 1 exactly when the free space, DEPTH minus `rev_level`, is at least the decoded room for `cfg_rev_thr`: 2'b00 → 4, 2'b01 → 8, 2'b10 → 16, 2'b11 → 32.
- R5: With `gap_en` high, a non-empty forward FIFO is released regardless of its threshold. The release comes `gap_limit`+1 clock edges after the edge that sampled its last push. With `gap_en` low, no release occurs.
- R6: Once released, a forward path stays asserted through further pushes until its level reads 0, or until `gap_en` goes low.
- R7: A push strobe restarts that path's idle count. A push arriving before the release postpones it to `gap_limit`+1 edges after the new push.
- R8: `host_ready` equals the ready bit last written through `cfg_we`.
- R9: The outputs are registered. A level change is visible after the next clock edge. A configuration write is captured at one edge and acts on the outputs at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the configuration register |
| cfg_cmd_thr | input | 2 | Command FIFO fill threshold code |
| cfg_dat_thr | input | 2 | Data FIFO fill threshold code |
| cfg_rev_thr | input | 2 | Reverse FIFO free-space code |
| cfg_cmd_dma | input | 1 | Command path mode: 1 DMA, 0 CPU |
| cfg_dat_dma | input | 1 | Data path mode: 1 DMA, 0 CPU |
| cfg_ready | input | 1 | Ready bit value |
| gap_en | input | 1 | Enables the idle-gap release |
| gap_limit | input | GAP_W | Idle cycles before a release |
| cmd_level | input | $clog2(DEPTH+1) | Command FIFO fill count |
| dat_level | input | $clog2(DEPTH+1) | Data FIFO fill count |
| rev_level | input | $clog2(DEPTH+1) | Reverse FIFO fill count |
| cmd_push | input | 1 | A byte entered the command FIFO |
| dat_push | input | 1 | A byte entered the data FIFO |
| cmd_dma_req | output | 1 | Command FIFO DMA request |
| dat_dma_req | output | 1 | Data FIFO DMA request |
| rev_dma_req | output | 1 | Reverse FIFO DMA request |
| cmd_cpu_svc | output | 1 | Command FIFO needs CPU service |
| dat_cpu_svc | output | 1 | Data FIFO needs CPU service |
| host_ready | output | 1 | Slave-ready indication to the host |

## Verification
The assertions assume that no fill level ever exceeds DEPTH. They also assume that a push strobe comes with a non-empty level in the same cycle. Without these, the empty-path and free-space properties would not be meaningful. The stimulus changes levels, strobes and configuration only one time unit after a rising edge and keeps every level between 0 and 32. The gap tests raise the level together with each push.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

  typedef struct packed {
    logic [1:0] cmd_thr;
    logic [1:0] dat_thr;
    logic [1:0] rev_thr;
    logic       cmd_dma;
    logic       dat_dma;
    logic       ready;
  } pgate_cfg_t;

  localparam pgate_cfg_t PGATE_CFG_RST = '{
    cmd_thr: 2'b11, dat_thr: 2'b11, rev_thr: 2'b11,
    cmd_dma: 1'b0,  dat_dma: 1'b0,  ready:   1'b0
  };

  // Minimum fill for a forward path, steps are uneven
  function automatic int unsigned fill_need(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 8;
      2'b10:   return 16;
      default: return 28;
    endcase
  endfunction

  // Room the reverse FIFO must offer (upper end of each band)
  function automatic int unsigned room_need(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 8;
      2'b10:   return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/pgate_cfg_reg.sv
module pgate_cfg_reg
  import pgate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  pgate_cfg_t cfg_d,
  output pgate_cfg_t cfg_q
);

  pgate_cfg_t cfg_r, cfg_nxt;

  always_comb begin
    cfg_nxt = cfg_r;
    if (we) cfg_nxt = cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_r <= PGATE_CFG_RST;
    else        cfg_r <= cfg_nxt;
  end

  assign cfg_q = cfg_r;

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> $stable(cfg_r));

endmodule

// File: rtl/pgate_fwd.sv
module pgate_fwd
  import pgate_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             push,
  input  logic [1:0]       thr,
  input  logic             dma_mode,
  input  logic             gap_en,
  input  logic [GAP_W-1:0] gap_limit,
  output logic             dma_req,
  output logic             cpu_svc
);

  localparam logic [LVL_W-1:0] LVL_ZERO = '0;

  logic [GAP_W-1:0] cnt_q, cnt_nxt;
  logic             rel_q, rel_nxt;
  logic             dma_q, dma_nxt;
  logic             svc_q, svc_nxt;
  logic [LVL_W-1:0] need;
  logic             above, idle_hit, go;

  assign need     = LVL_W'(fill_need(thr));
  assign above    = (level >= need);
  assign idle_hit = (cnt_q >= gap_limit);

  // idle counter: restarts on a push, saturates at the limit
  always_comb begin
    cnt_nxt = cnt_q;
    if (push || !gap_en)         cnt_nxt = '0;
    else if (cnt_q < gap_limit)  cnt_nxt = cnt_q + 1'b1;
  end

  // release latch: set by an expired gap, held until empty
  always_comb begin
    rel_nxt = rel_q;
    if (!gap_en || level == LVL_ZERO) rel_nxt = 1'b0;
    else if (idle_hit && !push)       rel_nxt = 1'b1;
  end

  always_comb begin
    go      = above || rel_nxt;
    dma_nxt = go &&  dma_mode;
    svc_nxt = go && !dma_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
      dma_q <= 1'b0;
      svc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      rel_q <= rel_nxt;
      dma_q <= dma_nxt;
      svc_q <= svc_nxt;
    end
  end

  assign dma_req = dma_q;
  assign cpu_svc = svc_q;

  // R3
  fwd_dma_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> $past(dma_mode));
  // R3
  fwd_cpu_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_q |-> !$past(dma_mode));
  // R6
  fwd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(level) == LVL_ZERO) |-> !(dma_q || svc_q));
  // R2
  fwd_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_q || svc_q) && ($past(level) < LVL_W'(4))) |-> $past(gap_en));

endmodule

// File: rtl/pgate_rev.sv
module pgate_rev
  import pgate_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       thr,
  output logic             req
);

  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] room, need;
  logic             req_q, req_nxt;

  assign room = FULL - level;
  assign need = LVL_W'(room_need(thr));

  always_comb begin
    req_nxt = (room >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_nxt;
  end

  assign req = req_q;

  // R4
  rev_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ($past(level) <= FULL - LVL_W'(4)));
  // R4
  rev_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(level) == FULL) |-> !req_q);

endmodule

// File: rtl/pgate_top.sv
module pgate_top
  import pgate_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int GAP_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_cmd_thr,
  input  logic [1:0]                 cfg_dat_thr,
  input  logic [1:0]                 cfg_rev_thr,
  input  logic                       cfg_cmd_dma,
  input  logic                       cfg_dat_dma,
  input  logic                       cfg_ready,
  input  logic                       gap_en,
  input  logic [GAP_W-1:0]           gap_limit,
  input  logic [$clog2(DEPTH+1)-1:0] cmd_level,
  input  logic [$clog2(DEPTH+1)-1:0] dat_level,
  input  logic [$clog2(DEPTH+1)-1:0] rev_level,
  input  logic                       cmd_push,
  input  logic                       dat_push,
  output logic                       cmd_dma_req,
  output logic                       dat_dma_req,
  output logic                       rev_dma_req,
  output logic                       cmd_cpu_svc,
  output logic                       dat_cpu_svc,
  output logic                       host_ready
);

  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int NFWD  = 2;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pgate_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d.cmd_thr = cfg_cmd_thr;
    cfg_d.dat_thr = cfg_dat_thr;
    cfg_d.rev_thr = cfg_rev_thr;
    cfg_d.cmd_dma = cfg_cmd_dma;
    cfg_d.dat_dma = cfg_dat_dma;
    cfg_d.ready   = cfg_ready;
  end

  pgate_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (cfg_we),
    .cfg_d (cfg_d),
    .cfg_q (cfg_q)
  );

  logic [NFWD-1:0][LVL_W-1:0] f_lvl;
  logic [NFWD-1:0][1:0]       f_thr;
  logic [NFWD-1:0]            f_push, f_mode, f_dma, f_svc;

  assign f_lvl  = {dat_level, cmd_level};
  assign f_thr  = {cfg_q.dat_thr, cfg_q.cmd_thr};
  assign f_push = {dat_push, cmd_push};
  assign f_mode = {cfg_q.dat_dma, cfg_q.cmd_dma};

  for (genvar i = 0; i < NFWD; i++) begin : g_fwd
    pgate_fwd #(.LVL_W(LVL_W), .GAP_W(GAP_W)) u_fwd (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .level     (f_lvl[i]),
      .push      (f_push[i]),
      .thr       (f_thr[i]),
      .dma_mode  (f_mode[i]),
      .gap_en    (gap_en),
      .gap_limit (gap_limit),
      .dma_req   (f_dma[i]),
      .cpu_svc   (f_svc[i])
    );
  end

  pgate_rev #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rev (
    .clk   (clk),
    .rst_n (rst_core_n),
    .level (rev_level),
    .thr   (cfg_q.rev_thr),
    .req   (rev_dma_req)
  );

  assign cmd_dma_req = f_dma[0];
  assign dat_dma_req = f_dma[1];
  assign cmd_cpu_svc = f_svc[0];
  assign dat_cpu_svc = f_svc[1];
  assign host_ready  = cfg_q.ready;

  // R8
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(host_ready) |-> $past(cfg_we));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_core_n |-> !(cmd_dma_req || dat_dma_req || rev_dma_req ||
                      cmd_cpu_svc || dat_cpu_svc || host_ready));

endmodule

// File: tb/tb_pgate_top.sv
module tb_pgate_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int GAP_W = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [1:0] cfg_cmd_thr, cfg_dat_thr, cfg_rev_thr;
  logic cfg_cmd_dma, cfg_dat_dma, cfg_ready;
  logic gap_en;
  logic [GAP_W-1:0] gap_limit;
  logic [LW-1:0] cmd_level, dat_level, rev_level;
  logic cmd_push, dat_push;
  logic cmd_dma_req, dat_dma_req, rev_dma_req, cmd_cpu_svc, dat_cpu_svc, host_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgate_top #(.DEPTH(DEPTH), .GAP_W(GAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_cmd_thr(cfg_cmd_thr), .cfg_dat_thr(cfg_dat_thr), .cfg_rev_thr(cfg_rev_thr),
    .cfg_cmd_dma(cfg_cmd_dma), .cfg_dat_dma(cfg_dat_dma), .cfg_ready(cfg_ready),
    .gap_en(gap_en), .gap_limit(gap_limit),
    .cmd_level(cmd_level), .dat_level(dat_level), .rev_level(rev_level),
    .cmd_push(cmd_push), .dat_push(dat_push),
    .cmd_dma_req(cmd_dma_req), .dat_dma_req(dat_dma_req), .rev_dma_req(rev_dma_req),
    .cmd_cpu_svc(cmd_cpu_svc), .dat_cpu_svc(dat_cpu_svc), .host_ready(host_ready)
  );

  typedef struct packed {
    logic [1:0] ct, dt, rt;
    logic       cd, dd;
    logic [5:0] cl, dl, rl;
    logic [4:0] exp; // {cmd_req, dat_req, rev_req, cmd_svc, dat_svc}
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 6'd4,  6'd3,  6'd28, 5'b10100},
    '{2'b01, 2'b01, 2'b01, 1'b1, 1'b0, 6'd7,  6'd8,  6'd25, 5'b00001},
    '{2'b10, 2'b10, 2'b10, 1'b0, 1'b1, 6'd16, 6'd15, 6'd16, 5'b00110},
    '{2'b11, 2'b11, 2'b11, 1'b1, 1'b1, 6'd28, 6'd27, 6'd0,  5'b10100},
    '{2'b11, 2'b11, 2'b11, 1'b0, 1'b0, 6'd32, 6'd32, 6'd1,  5'b00011},
    '{2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 6'd3,  6'd0,  6'd29, 5'b00000},
    '{2'b10, 2'b00, 2'b11, 1'b1, 1'b0, 6'd20, 6'd4,  6'd0,  5'b10101}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [4:0] outs();
    return {cmd_dma_req, dat_dma_req, rev_dma_req, cmd_cpu_svc, dat_cpu_svc};
  endfunction

  task automatic write_cfg(input logic [1:0] ct, input logic [1:0] dt, input logic [1:0] rt,
                           input logic cd, input logic dd, input logic rdy);
    cfg_cmd_thr = ct; cfg_dat_thr = dt; cfg_rev_thr = rt;
    cfg_cmd_dma = cd; cfg_dat_dma = dd; cfg_ready = rdy;
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0;
    cfg_cmd_thr = 2'b00; cfg_dat_thr = 2'b00; cfg_rev_thr = 2'b00;
    cfg_cmd_dma = 1'b1; cfg_dat_dma = 1'b1; cfg_ready = 1'b1;
    gap_en = 1'b0; gap_limit = '0;
    cmd_level = 6'd30; dat_level = 6'd30; rev_level = 6'd0;
    cmd_push = 1'b0; dat_push = 1'b0;
    repeat (3) tick();
    // R1: outputs quiet in reset even with levels above every threshold
    check("R1 outputs in reset", {27'd0, outs()}, 32'd0);
    check("R1 host_ready in reset", host_ready, 1'b0);
    cmd_level = 6'd27; dat_level = 6'd0; rev_level = 6'd1;
    rst_n = 1'b1;
    repeat (4) tick();
    // R1: reset thresholds are code 11, modes are CPU
    check("R1 cmd 27 below reset threshold", {27'd0, outs()}, 32'd0);
    check("R1 host_ready after reset", host_ready, 1'b0);
    cmd_level = 6'd28; rev_level = 6'd0;
    #2;
    // R9: nothing changes before the edge
    check("R9 no change before edge", {27'd0, outs()}, 32'd0);
    tick();
    // R1 R9: CPU mode flag at 28, reverse needs all 32 bytes free
    check("R1 reset mode CPU / reset codes", {27'd0, outs()}, {27'd0, 5'b00110});

    // R9: config capture then effect one edge later
    write_cfg(2'b11, 2'b11, 2'b11, 1'b1, 1'b0, 1'b0);
    check("R9 cfg not yet active", {27'd0, outs()}, {27'd0, 5'b00110});
    tick();
    check("R9 cfg active next edge", {27'd0, outs()}, {27'd0, 5'b10100});

    // R8
    write_cfg(2'b11, 2'b11, 2'b11, 1'b1, 1'b0, 1'b1);
    check("R8 ready set", host_ready, 1'b1);
    write_cfg(2'b11, 2'b11, 2'b11, 1'b1, 1'b0, 1'b0);
    check("R8 ready cleared", host_ready, 1'b0);

    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      cmd_level = VEC[i].cl; dat_level = VEC[i].dl; rev_level = VEC[i].rl;
      write_cfg(VEC[i].ct, VEC[i].dt, VEC[i].rt, VEC[i].cd, VEC[i].dd, 1'b0);
      tick();
      check($sformatf("R2 R3 R4 vector %0d", i), {27'd0, outs()}, {27'd0, VEC[i].exp});
    end

    // R5 gap release on command path, limit 3
    cmd_level = 6'd0; dat_level = 6'd0; rev_level = 6'd32;
    write_cfg(2'b11, 2'b11, 2'b11, 1'b1, 1'b1, 1'b0);
    gap_en = 1'b1; gap_limit = 8'd3;
    repeat (3) tick();
    cmd_push = 1'b1; cmd_level = 6'd2;
    tick();
    cmd_push = 1'b0;
    check("R5 no release at push", cmd_dma_req, 1'b0);
    repeat (3) tick();
    check("R5 no release at limit edge", cmd_dma_req, 1'b0);
    tick();
    check("R5 release at limit+1", cmd_dma_req, 1'b1);

    // R6 hold through push, drop at empty
    cmd_push = 1'b1; cmd_level = 6'd3;
    tick();
    cmd_push = 1'b0;
    check("R6 held through push", cmd_dma_req, 1'b1);
    tick();
    check("R6 still held", cmd_dma_req, 1'b1);
    cmd_level = 6'd0;
    tick();
    check("R6 dropped at empty", cmd_dma_req, 1'b0);

    // R7 restart of idle count
    cmd_push = 1'b1; cmd_level = 6'd1;
    tick();
    cmd_push = 1'b0;
    tick();
    cmd_push = 1'b1; cmd_level = 6'd2;
    tick();
    cmd_push = 1'b0;
    repeat (3) tick();
    check("R7 postponed by second push", cmd_dma_req, 1'b0);
    tick();
    check("R7 release after restart", cmd_dma_req, 1'b1);

    // R6 gap_en low clears release; R5 no release while disabled
    gap_en = 1'b0;
    tick();
    check("R6 cleared by gap_en low", cmd_dma_req, 1'b0);
    repeat (10) tick();
    check("R5 no release when disabled", cmd_dma_req, 1'b0);

    // R5 limit zero, data path in CPU mode
    cmd_level = 6'd0;
    write_cfg(2'b11, 2'b11, 2'b11, 1'b1, 1'b0, 1'b0);
    gap_en = 1'b1; gap_limit = 8'd0;
    tick();
    dat_push = 1'b1; dat_level = 6'd1;
    tick();
    dat_push = 1'b0;
    check("R5 limit0 not at push edge", dat_cpu_svc, 1'b0);
    tick();
    check("R5 limit0 release next edge", dat_cpu_svc, 1'b1);
    check("R3 data in CPU mode no dma", dat_dma_req, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule